// File: doc/BRIEF.md
# Write Completion Status Responder

This block sits on the read-data path of a self-timed non-volatile byte memory. While the write controller reports that an internal programming cycle is running, it replaces normal array data with status. Any host read during that time returns two early-completion indicators. The top data bit carries the inverse of the top bit of the last byte loaded. The next bit down changes level on every separate read access. All remaining bits read as zero.

When the busy indication drops, reads pass the array data through unchanged. The host can then detect the end of programming in either of two ways. It can compare the top bit against the byte it wrote, or it can read twice and see whether the toggle bit has stopped moving.

The read path is synchronous. The chip-select and output-enable levels are sampled on each clock edge, and the returned byte and the bus enable are registered, one cycle after the sample. Analogue access timing and the tri-state pads themselves belong to the surrounding logic.

Top module: `wcs_status_responder`

## Requirements
- R1: After reset the bus enable and the read data are low, the stored last byte is 0x00 and the toggle level is 0, so the first status read after reset returns 0xC0.
- R2: The bus enable is high in the cycle after a sample with both active-low selects (`sel_n_i`, `oen_n_i`) low, and low otherwise; while it is low the read data is 0x00.
- R3: In the cycle after a selected sample with `busy_i` high, data bit 7 equals the inverse of bit 7 of the stored last byte.
- R4: While busy, data bit 6 changes level once at the first sample of each distinct access (selects going from not-both-low to both-low). It holds its level for the remaining cycles of that access.
- R5: While busy, data bits 5 to 0 of a selected read are 0.
- R6: In the cycle after a selected sample with `busy_i` low, the read data equals the `array_i` value of that sample. This also holds in an access that began while busy.
- R7: Accesses made while not busy leave the toggle level unchanged, so the toggle sequence resumes in the next busy period from where it stopped.
- R8: A pulse on `load_i` while not busy stores `load_data_i` as the last byte, and the latest such load wins. Loads while busy are ignored.
- R9: While busy, the status byte does not depend on `array_i`, whatever location is being read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy_i | input | 1 | Internal programming cycle in progress |
| load_i | input | 1 | One-cycle strobe: a byte was loaded for programming |
| load_data_i | input | DATA_W | Byte loaded with `load_i` |
| sel_n_i | input | 1 | Active-low chip select |
| oen_n_i | input | 1 | Active-low output enable |
| array_i | input | DATA_W | Array data for the addressed location |
| rd_data_o | output | DATA_W | Returned read byte |
| rd_drive_o | output | 1 | Data bus enable |

## Verification
The bench builds the block with its defaults: an 8-bit data path, the polling bit on bit 7, the toggle bit on bit 6, and reserved bits filled with zero. With these values, every status byte value (0x00, 0x40, 0x80, 0xC0) can be reached from a short table by choosing the stored top bit and the number of accesses. Array data chosen with each bit pattern shows whether passthrough or substitution is active. A reset in the middle of a busy access shows that the toggle and the stored byte return to their initial values.

// File: rtl/wcs_pkg.sv
package wcs_pkg;

    // Source of the byte returned on a read
    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_STATUS = 2'd1,
        SRC_ARRAY  = 2'd2
    } rd_src_e;

endpackage

// File: rtl/wcs_last_byte.sv
module wcs_last_byte #(
    parameter int DATA_W   = 8,
    parameter int PEND_BIT = DATA_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy_i,
    input  logic              load_i,
    input  logic [DATA_W-1:0] load_data_i,
    output logic              pend_o
);

    typedef struct packed {
        logic [DATA_W-1:0] last;
    } cap_state_t;

    cap_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i && !busy_i) begin
            st_d.last = load_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.last[PEND_BIT];

    AST_LOAD_BLOCKED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> $stable(st_q.last)); // R8

    AST_LOAD_TAKEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !busy_i) |=> (st_q.last == $past(load_data_i))); // R8

endmodule

// File: rtl/wcs_toggle.sv
module wcs_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_i,
    input  logic sel_i,
    output logic tog_o
);

    typedef struct packed {
        logic sel;
        logic tog;
    } tog_state_t;

    tog_state_t st_d, st_q;
    logic       access_start;

    always_comb begin
        st_d         = st_q;
        access_start = sel_i && !st_q.sel;
        st_d.sel     = sel_i;
        if (access_start && busy_i) begin
            st_d.tog = ~st_q.tog;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Level presented for the access sampled this cycle
    assign tog_o = st_d.tog;

    AST_TOG_FROZEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_i |=> $stable(st_q.tog)); // R7

    AST_TOG_HELD_IN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && $past(sel_i) && $past(rst_n)) |=> $stable(st_q.tog)); // R4

endmodule

// File: rtl/wcs_read_mux.sv
module wcs_read_mux
    import wcs_pkg::*;
#(
    parameter int   DATA_W   = 8,
    parameter int   PEND_BIT = DATA_W - 1,
    parameter int   TOG_BIT  = DATA_W - 2,
    parameter logic RSV_FILL = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              busy_i,
    input  logic              pend_i,
    input  logic              tog_i,
    input  logic [DATA_W-1:0] array_i,
    output logic [DATA_W-1:0] data_o,
    output logic              drive_o
);

    typedef struct packed {
        rd_src_e           src;
        logic              drive;
        logic [DATA_W-1:0] data;
    } mux_state_t;

    mux_state_t        st_d, st_q;
    logic [DATA_W-1:0] status_byte;

    for (genvar b = 0; b < DATA_W; b++) begin : g_status
        if (b == PEND_BIT) begin : g_pend
            assign status_byte[b] = ~pend_i;
        end else if (b == TOG_BIT) begin : g_tog
            assign status_byte[b] = tog_i;
        end else begin : g_rsv
            assign status_byte[b] = RSV_FILL;
        end
    end

    always_comb begin
        st_d = st_q;
        if (!sel_i) begin
            st_d.src = SRC_NONE;
        end else if (busy_i) begin
            st_d.src = SRC_STATUS;
        end else begin
            st_d.src = SRC_ARRAY;
        end
        st_d.drive = (st_d.src != SRC_NONE);
        unique case (st_d.src)
            SRC_STATUS: st_d.data = status_byte;
            SRC_ARRAY:  st_d.data = array_i;
            default:    st_d.data = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{src: SRC_NONE, drive: 1'b0, data: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o  = st_q.data;
    assign drive_o = st_q.drive;

    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !drive_o |-> (data_o == '0)); // R2

    AST_PASS_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && !busy_i) |=> (data_o == $past(array_i))); // R6

endmodule

// File: rtl/wcs_status_responder.sv
module wcs_status_responder #(
    parameter int   DATA_W   = 8,
    parameter logic RSV_FILL = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy_i,
    input  logic              load_i,
    input  logic [DATA_W-1:0] load_data_i,
    input  logic              sel_n_i,
    input  logic              oen_n_i,
    input  logic [DATA_W-1:0] array_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_drive_o
);

    localparam int PEND_BIT = DATA_W - 1;
    localparam int TOG_BIT  = DATA_W - 2;

    logic rd_sel;
    logic pend_w;
    logic tog_w;

    assign rd_sel = !sel_n_i && !oen_n_i;

    wcs_last_byte #(
        .DATA_W   (DATA_W),
        .PEND_BIT (PEND_BIT)
    ) last_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .busy_i      (busy_i),
        .load_i      (load_i),
        .load_data_i (load_data_i),
        .pend_o      (pend_w)
    );

    wcs_toggle tog_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .busy_i (busy_i),
        .sel_i  (rd_sel),
        .tog_o  (tog_w)
    );

    wcs_read_mux #(
        .DATA_W   (DATA_W),
        .PEND_BIT (PEND_BIT),
        .TOG_BIT  (TOG_BIT),
        .RSV_FILL (RSV_FILL)
    ) mux_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_i   (rd_sel),
        .busy_i  (busy_i),
        .pend_i  (pend_w),
        .tog_i   (tog_w),
        .array_i (array_i),
        .data_o  (rd_data_o),
        .drive_o (rd_drive_o)
    );

    AST_DRIVE_FOLLOWS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        rd_sel |=> rd_drive_o); // R2

    AST_NO_DRIVE_UNSEL: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_sel |=> !rd_drive_o); // R2

    AST_POLL_INVERTED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel && busy_i) |=> (rd_data_o[PEND_BIT] != $past(pend_w))); // R3

    AST_TOG_STABLE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel && $past(rd_sel) && busy_i && $past(busy_i) && $past(rst_n))
        |=> $stable(rd_data_o[TOG_BIT])); // R4

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel && busy_i) |=> (rd_data_o[TOG_BIT-1:0] == '0)); // R5

endmodule

// File: tb/wcs_status_responder_tb.sv
module wcs_status_responder_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       busy = 1'b0;
    logic       load = 1'b0;
    logic [7:0] load_data = '0;
    logic       sel_n = 1'b1;
    logic       oen_n = 1'b1;
    logic [7:0] arr = '0;
    logic [7:0] rd_data;
    logic       rd_drive;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    wcs_status_responder dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .busy_i      (busy),
        .load_i      (load),
        .load_data_i (load_data),
        .sel_n_i     (sel_n),
        .oen_n_i     (oen_n),
        .array_i     (arr),
        .rd_data_o   (rd_data),
        .rd_drive_o  (rd_drive)
    );

    typedef struct packed {
        logic       busy;
        logic       sel_n;
        logic       oen_n;
        logic       ld;
        logic [7:0] wd;
        logic [7:0] arr;
        logic       edrv;
        logic [7:0] edata;
        logic [7:0] req;
    } vec_t;

    // Each row is applied for one cycle; the expected values are those
    // visible after the clock edge that samples the row.
    localparam vec_t VEC [0:18] = '{
        '{1'b0, 1'b1, 1'b1, 1'b1, 8'h35, 8'h00, 1'b0, 8'h00, 8'd8}, // R8 load
        '{1'b0, 1'b1, 1'b1, 1'b1, 8'h5A, 8'h00, 1'b0, 8'h00, 8'd8}, // R8 latest wins
        '{1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'hC3, 1'b1, 8'hC0, 8'd3}, // R3 R5 toggle to 1
        '{1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h11, 1'b1, 8'hC0, 8'd4}, // R4 R9 same access
        '{1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 8'hFF, 1'b0, 8'h00, 8'd2}, // R2 select high
        '{1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h77, 1'b1, 8'h80, 8'd4}, // R4 new access
        '{1'b1, 1'b0, 1'b1, 1'b1, 8'hFF, 8'h00, 1'b0, 8'h00, 8'd2}, // R2 R8 busy load
        '{1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 8'hC0, 8'd8}, // R8 still 5A
        '{1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0, 8'h00, 8'd2},
        '{1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'hA5, 1'b1, 8'hA5, 8'd6}, // R6 passthrough
        '{1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0, 8'h00, 8'd2},
        '{1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h3C, 1'b1, 8'h3C, 8'd6}, // R6 R7 idle access
        '{1'b0, 1'b1, 1'b1, 1'b1, 8'h9E, 8'h00, 1'b0, 8'h00, 8'd8}, // R8 load 9E
        '{1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0, 8'h00, 8'd2},
        '{1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'hFF, 1'b1, 8'h00, 8'd7}, // R7 resumes to 0
        '{1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0, 8'h00, 8'd2},
        '{1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 8'h40, 8'd4}, // R4 R5
        '{1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h81, 1'b1, 8'h81, 8'd6}, // R6 busy fell
        '{1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h66, 1'b0, 8'h00, 8'd2}  // R2 only oe low
    };

    task automatic check(input string req, input logic adrv, input logic [7:0] adat,
                         input logic edrv, input logic [7:0] edat);
        n_checks++;
        if (adrv !== edrv || adat !== edat) begin
            n_fail++;
            $display("FAIL %s: drive=%0b data=%02h expected drive=%0b data=%02h",
                     req, adrv, adat, edrv, edat);
        end
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset state", rd_drive, rd_data, 1'b0, 8'h00);

        for (int i = 0; i < 19; i++) begin
            busy      = VEC[i].busy;
            sel_n     = VEC[i].sel_n;
            oen_n     = VEC[i].oen_n;
            load      = VEC[i].ld;
            load_data = VEC[i].wd;
            arr       = VEC[i].arr;
            @(negedge clk);
            check($sformatf("R%0d vector %0d", VEC[i].req, i),
                  rd_drive, rd_data, VEC[i].edrv, VEC[i].edata);
        end
        load = 1'b0;

        // R1: reset in the middle of a busy access
        busy  = 1'b1;
        sel_n = 1'b1;
        oen_n = 1'b1;
        @(negedge clk);
        sel_n = 1'b0;
        oen_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid access", rd_drive, rd_data, 1'b0, 8'h00);
        sel_n = 1'b1;
        oen_n = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        sel_n = 1'b0;
        oen_n = 1'b0;
        arr   = 8'h5F;
        @(negedge clk);
        check("R1 first status after reset", rd_drive, rd_data, 1'b1, 8'hC0);

        // R9: substitution holds across changing array data within an access
        arr = 8'h00;
        @(negedge clk);
        check("R9 array ignored while busy", rd_drive, rd_data, 1'b1, 8'hC0);

        // R6: busy drops, same access now returns the array
        busy = 1'b0;
        @(negedge clk);
        check("R6 true data after busy", rd_drive, rd_data, 1'b1, 8'h00);
        sel_n = 1'b1;
        oen_n = 1'b1;
        @(negedge clk);
        check("R2 released", rd_drive, rd_data, 1'b0, 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule